// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal clocked bus and an external asynchronous static RAM of 128K words by 16 bits with separate byte-lane selects. It accepts one single-word read or write at a time through a valid/ready handshake with a per-byte lane mask. Each request becomes a sequence of active-low strobes whose phase lengths come from nanosecond timing parameters divided by the clock period. A phase count is the ceiling of the required nanoseconds over the period, and never less than one cycle.

The data bus is split into an outgoing word, an incoming word and a drive enable for an external tristate buffer. A read holds chip enable and output enable low for the whole read cycle time. The incoming word is captured on the last read cycle and returned with a one-cycle valid pulse. Every read then ends with a turnaround phase in which nothing is driven, so the memory can float its outputs before the controller drives the bus again. A write has three phases: a setup phase with the data driven and write enable high, a write-enable low pulse, and a recovery phase that stretches the whole write to the write cycle time. The address never moves while write enable is low.

States and transitions, all named: IDLE goes to RD on an accepted read, or to WSET on an accepted write. RD goes to TURN when its count expires, and TURN goes to IDLE. WSET goes to WPUL, WPUL goes to WREC, and WREC goes back to IDLE, each when its count expires. With the default parameters and a 4 ns clock, the phases are RD 14 cycles, TURN 5, WSET 1, WPUL 10 and WREC 3.

Top module: `asram_ctrl`

## Requirements
- R1: In IDLE and after synchronous reset, `req_ready` is 1, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are all 1, `sram_dout_en` is 0 and `rsp_valid` is 0.
- R2: `req_ready` is 0 from the cycle after acceptance until the operation ends. A read returns to ready after RD+TURN cycles and a write after WSET+WPUL+WREC cycles. A request presented while `req_ready` is 0 is ignored.
- R3: During a read, `sram_ce_n` and `sram_oe_n` are 0 and `sram_we_n` is 1 for exactly RD cycles, and `sram_dout_en` stays 0.
- R4: The read word is captured on the last RD cycle. `rsp_valid` is 1 for exactly one cycle, the first TURN cycle, with `rsp_rdata` carrying the memory lanes that were selected and zero in the deselected lanes.
- R5: A write holds `sram_ce_n` at 0 throughout. `sram_we_n` is 1 for WSET cycles, 0 for exactly WPUL cycles, then 1 for WREC cycles.
- R6: Throughout a write, `sram_dout_en` is 1 and `sram_dout` equals the request data. Only the lanes whose mask bit is 1 are written, and a mask of 0 leaves the word unchanged.
- R7: `sram_addr` takes the request address at acceptance and stays stable until the operation ends. In particular it never changes while `sram_we_n` is 0.
- R8: Once `sram_oe_n` rises, `sram_dout_en` stays 0 for at least TURN cycles.
- R9: The phase counts are: RD = ceil(read cycle / clk); TURN = ceil(float time / clk); WSET = ceil(address setup / clk); WPUL = max(ceil(write pulse / clk), ceil(data setup / clk)); WREC = max(1, ceil(write cycle / clk) - WSET - WPUL). Each count is at least 1.
- R10: `sram_oe_n` is never 0 while `sram_dout_en` is 1, and `sram_we_n` is never 0 while `sram_ce_n` is 1.
- R11: Mask bit 0 drives `sram_lb_n` (data bits 7..0) and mask bit 1 drives `sram_ub_n` (bits 15..8). A lane select is 0 only while `sram_ce_n` is 0 and that lane's mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, deselected lanes zero |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte select, active low |
| sram_lb_n | output | 1 | Lower byte select, active low |
| sram_dout | output | 16 | Data toward memory |
| sram_din | input | 16 | Data from memory |
| sram_dout_en | output | 1 | Drive enable for the tristate buffer |

## Verification
All strobes change on the edge that accepts a request. The bench therefore samples cycle k of an operation at the falling edge after acceptance edge plus k and compares each pin against the phase schedule computed from R9. This gives RD=14, TURN=5, WSET=1, WPUL=10 and WREC=3 at a 4 ns clock. The read word and `rsp_valid` are due in cycle RD, and ready returns in cycle RD+TURN for reads or WSET+WPUL+WREC for writes; the bench samples exactly those cycles. Lane writes are judged afterwards by reading the word back under every mask, against a reference array the bench updates arithmetically.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WREC
    } asram_state_e;

    // ceiling of ns / clk, never below one cycle
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > 1) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_ctrl_pkg::*;
#(
    parameter int unsigned CW      = 8,
    parameter int unsigned RD_CYC  = 14,
    parameter int unsigned TA_CYC  = 5,
    parameter int unsigned SU_CYC  = 1,
    parameter int unsigned WP_CYC  = 10,
    parameter int unsigned REC_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_wr,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          cap,
    output logic          ready,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          drive
);

    asram_state_e state_q, state_d;

    assign accept = req_valid && ready;
    assign cap    = (state_q == ST_RD) && tmr_last;

    // next state and phase counter loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_wr) begin
                        state_d = ST_WSET;
                        tmr_val = CW'(SU_CYC);
                    end else begin
                        state_d = ST_RD;
                        tmr_val = CW'(RD_CYC);
                    end
                end
            end
            ST_RD: begin
                if (tmr_last) begin
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(TA_CYC);
                end
            end
            ST_TURN: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            ST_WSET: begin
                if (tmr_last) begin
                    state_d  = ST_WPUL;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(WP_CYC);
                end
            end
            ST_WPUL: begin
                if (tmr_last) begin
                    state_d  = ST_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(REC_CYC);
                end
            end
            ST_WREC: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered strobes decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b1;
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            drive <= 1'b0;
        end else begin
            ready <= (state_d == ST_IDLE);
            unique case (state_d)
                ST_RD: begin
                    ce_n <= 1'b0; we_n <= 1'b1; oe_n <= 1'b0; drive <= 1'b0;
                end
                ST_WSET, ST_WREC: begin
                    ce_n <= 1'b0; we_n <= 1'b1; oe_n <= 1'b1; drive <= 1'b1;
                end
                ST_WPUL: begin
                    ce_n <= 1'b0; we_n <= 1'b0; oe_n <= 1'b1; drive <= 1'b1;
                end
                default: begin
                    ce_n <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1; drive <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int unsigned AW    = 17,
    parameter int unsigned DW    = 16,
    parameter int unsigned LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             cap,
    input  logic             ce_n,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_be,
    input  logic [DW-1:0]    sram_din,
    output logic [AW-1:0]    sram_addr,
    output logic [DW-1:0]    sram_dout,
    output logic [LANES-1:0] sel_n,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata
);

    logic [LANES-1:0] be_q;
    logic [DW-1:0]    rd_masked;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sel_n[l]             = ~(be_q[l] & ~ce_n);
        assign rd_masked[l*8 +: 8] = be_q[l] ? sram_din[l*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr <= '0;
            sram_dout <= '0;
            be_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                sram_addr <= req_addr;
                sram_dout <= req_wdata;
                be_q      <= req_be;
            end
            rsp_valid <= cap;
            if (cap) rsp_rdata <= rd_masked;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS   = 4,
    parameter int unsigned T_RC_NS  = 55,
    parameter int unsigned T_HZ_NS  = 20,
    parameter int unsigned T_AS_NS  = 0,
    parameter int unsigned T_WP_NS  = 40,
    parameter int unsigned T_DS_NS  = 35,
    parameter int unsigned T_WC_NS  = 55,
    parameter int unsigned AW       = 17,
    parameter int unsigned DW       = 16,
    localparam int unsigned LANES   = DW / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_wr,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_be,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    sram_addr,
    output logic             sram_ce_n,
    output logic             sram_we_n,
    output logic             sram_oe_n,
    output logic             sram_ub_n,
    output logic             sram_lb_n,
    output logic [DW-1:0]    sram_dout,
    input  logic [DW-1:0]    sram_din,
    output logic             sram_dout_en
);

    localparam int unsigned CW      = 8;
    localparam int unsigned RD_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int unsigned TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned SU_CYC  = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int unsigned WP_CYC  = max_u(ns_to_cyc(T_WP_NS, CLK_NS),
                                            ns_to_cyc(T_DS_NS, CLK_NS));
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned REC_CYC = (WC_CYC > SU_CYC + WP_CYC + 1)
                                      ? WC_CYC - SU_CYC - WP_CYC : 1;

    logic          tmr_load, tmr_last, accept, cap;
    logic [CW-1:0] tmr_val;
    logic [LANES-1:0] sel_n;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    asram_fsm #(
        .CW(CW), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC),
        .SU_CYC(SU_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .cap       (cap),
        .ready     (req_ready),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .drive     (sram_dout_en)
    );

    asram_dpath #(.AW(AW), .DW(DW), .LANES(LANES)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cap       (cap),
        .ce_n      (sram_ce_n),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .sram_din  (sram_din),
        .sram_addr (sram_addr),
        .sram_dout (sram_dout),
        .sel_n     (sel_n),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // lane 0 is the low byte, lane 1 the high byte
    assign sram_lb_n = sel_n[0];
    assign sram_ub_n = sel_n[LANES-1];

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int unsigned AW     = 17,
    parameter int unsigned TA_CYC = 5,
    parameter int unsigned WP_CYC = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] sram_addr,
    input logic          sram_ce_n,
    input logic          sram_we_n,
    input logic          sram_oe_n,
    input logic          sram_dout_en
);

    logic [7:0] we_low_cnt;
    logic [7:0] oe_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= 8'hFF;
        end else begin
            we_low_cnt <= sram_we_n ? 8'd0
                        : (we_low_cnt == 8'hFF ? we_low_cnt : we_low_cnt + 8'd1);
            if (!sram_oe_n)               oe_high_cnt <= '0;
            else if (oe_high_cnt != 8'hFF) oe_high_cnt <= oe_high_cnt + 8'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dout_en));

    assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_we_pulse_len_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_low_cnt >= 8'(WP_CYC)));

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(sram_addr));

    assert_addr_we_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dout_en) |-> (oe_high_cnt >= 8'(TA_CYC)));

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
        !(sram_dout_en && !sram_oe_n));

    assert_we_needs_ce_R10: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .TA_CYC(TA_CYC), .WP_CYC(WP_CYC)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .sram_addr    (sram_addr),
    .sram_ce_n    (sram_ce_n),
    .sram_we_n    (sram_we_n),
    .sram_oe_n    (sram_oe_n),
    .sram_dout_en (sram_dout_en)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

    // phase counts from R9 at a 4 ns clock with the default ns values
    localparam int CLK = 4;
    localparam int BRD  = (55 + CLK - 1) / CLK;                    // 14
    localparam int BTA  = (20 + CLK - 1) / CLK;                    // 5
    localparam int BSU  = 1;                                       // 0 ns -> 1
    localparam int BWP  = ((40 + CLK - 1) / CLK > (35 + CLK - 1) / CLK)
                          ? (40 + CLK - 1) / CLK : (35 + CLK - 1) / CLK; // 10
    localparam int BWC  = (55 + CLK - 1) / CLK;                    // 14
    localparam int BREC = (BWC - BSU - BWP > 1) ? BWC - BSU - BWP : 1; // 3

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_wr;
    logic [16:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
    logic [15:0] sram_dout, sram_din;
    logic        sram_dout_en;

    int errors = 0;
    int checks = 0;

    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];

    always #2 clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dout(sram_dout), .sram_din(sram_din), .sram_dout_en(sram_dout_en)
    );

    // memory model: deselected lanes return junk 0xA5
    assign sram_din[7:0]  = (!sram_ce_n && !sram_oe_n && !sram_lb_n)
                            ? mem[sram_addr[7:0]][7:0]  : 8'hA5;
    assign sram_din[15:8] = (!sram_ce_n && !sram_oe_n && !sram_ub_n)
                            ? mem[sram_addr[7:0]][15:8] : 8'hA5;

    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0 && sram_dout_en === 1'b1) begin
            if (!sram_lb_n) mem[sram_addr[7:0]][7:0]  <= sram_dout[7:0];
            if (!sram_ub_n) mem[sram_addr[7:0]][15:8] <= sram_dout[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one operation, pins compared every cycle against the R9 schedule
    task automatic do_op(input bit wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        int total;
        int bad_strobe = 0, bad_lane = 0, bad_addr = 0, bad_rdy = 0;
        int bad_data = 0, bad_rv = 0;
        logic [15:0] exp_rd;
        logic [15:0] got_rd = '0;
        exp_rd = {be[1] ? ref_mem[a[7:0]][15:8] : 8'h00,
                  be[0] ? ref_mem[a[7:0]][7:0]  : 8'h00};
        total = wr ? (BSU + BWP + BREC) : (BRD + BTA);
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before accept", 32'(req_ready), 1);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        for (int k = 0; k < total; k++) begin
            bit e_ce, e_we, e_oe, e_en, in_acc;
            if (wr) begin
                in_acc = 1'b1;
                e_ce = 1'b0; e_oe = 1'b1; e_en = 1'b1;
                e_we = !(k >= BSU && k < BSU + BWP);
            end else begin
                in_acc = (k < BRD);
                e_ce = !in_acc; e_oe = !in_acc; e_we = 1'b1; e_en = 1'b0;
            end
            if (sram_ce_n !== e_ce || sram_we_n !== e_we || sram_oe_n !== e_oe ||
                sram_dout_en !== e_en) bad_strobe++;
            if (sram_lb_n !== !(in_acc && be[0]) || sram_ub_n !== !(in_acc && be[1]))
                bad_lane++;
            if (sram_addr !== a) bad_addr++;
            if (req_ready !== 1'b0) bad_rdy++;
            if (wr && sram_dout !== d) bad_data++;
            if (rsp_valid !== (!wr && k == BRD)) bad_rv++;
            if (!wr && k == BRD) got_rd = rsp_rdata;
            // a second request while busy must be ignored
            req_addr = a ^ 17'h00001;
            req_wr   = !wr;
            req_valid = (k != total - 1);
            @(negedge clk);
        end
        if (wr) begin
            check(bad_strobe == 0, "R5 write strobe phases", 32'(bad_strobe), 0);
            check(bad_data == 0, "R6 write data driven", 32'(bad_data), 0);
            for (int l = 0; l < 2; l++)
                if (be[l]) ref_mem[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
        end else begin
            check(bad_strobe == 0, "R3 read strobe phases", 32'(bad_strobe), 0);
            check(bad_rv == 0, "R4 rsp_valid single pulse", 32'(bad_rv), 0);
            check(got_rd === exp_rd, "R4 read data lanes", 32'(got_rd), 32'(exp_rd));
        end
        check(bad_lane == 0, "R11 lane selects", 32'(bad_lane), 0);
        check(bad_addr == 0, "R7 address stable", 32'(bad_addr), 0);
        check(bad_rdy == 0, "R2 ready low while busy", 32'(bad_rdy), 0);
        check(req_ready === 1'b1 && sram_ce_n === 1'b1 && sram_dout_en === 1'b0,
              "R2 R9 ready returns on schedule", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 16'hC3C3 ^ 16'(i * 16'h0101);
            ref_mem[i] = 16'hC3C3 ^ 16'(i * 16'h0101);
        end
        rst = 1'b1; req_valid = 1'b0; req_wr = 1'b0;
        req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(req_ready === 1'b1 && sram_ce_n === 1'b1 && sram_we_n === 1'b1 &&
              sram_oe_n === 1'b1 && sram_ub_n === 1'b1 && sram_lb_n === 1'b1 &&
              sram_dout_en === 1'b0 && rsp_valid === 1'b0,
              "R1 idle after reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_dout_en},
              32'b1110);
        // R9 derived counts
        check(BRD == 14 && BTA == 5 && BWP == 10 && BREC == 3, "R9 phase counts",
              32'(BREC), 3);
        // full-word writes, then read back
        for (int i = 0; i < 8; i++)
            do_op(1'b1, 17'h1FF00 + 17'(i), 16'(16'h1234 * (i + 1)), 2'b11);
        for (int i = 0; i < 8; i++)
            do_op(1'b0, 17'h1FF00 + 17'(i), 16'h0000, 2'b11);
        // R6 partial writes under every mask, including mask 0
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 4; i++)
                do_op(1'b1, 17'h00040 + 17'(m * 4 + i), 16'(16'hA0F1 + m * 16'h1111 + i),
                      2'(m));
        // read every lane mask over those words
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 16; i += 3)
                do_op(1'b0, 17'h00040 + 17'(i), 16'h0000, 2'(m));
        // read directly followed by a write: turnaround then drive
        do_op(1'b0, 17'h0ABCD, 16'h0000, 2'b11);
        do_op(1'b1, 17'h0ABCD, 16'h5AA5, 2'b01);
        do_op(1'b0, 17'h0ABCD, 16'h0000, 2'b11);
        @(negedge clk);
        check(req_ready === 1'b1 && sram_oe_n === 1'b1 && rsp_valid === 1'b0,
              "R1 idle at end", 32'(req_ready), 1);
        finish_run();
    end

endmodule